// File: doc/BRIEF.md
# DC Offset Removal Filter

This block strips a slowly drifting DC offset from a stream of signed samples. It tracks the offset with a digital model of an RC smoothing network. On every accepted sample, the gap between the sample and the current offset estimate is scaled by a fractional gain and added into a wide accumulator. The integer half of that accumulator is the offset estimate.

Each accepted sample also has the pre-update estimate subtracted from it. The result is clamped to the signed sample range and presented one clock later with its own valid flag.

The gain is an unsigned fraction that may be changed between any two samples. A large gain reaches the offset level quickly but ripples. A small gain settles slowly but gives a steady estimate. The fractional half of the accumulator keeps even the tiniest scaled corrections, so the estimate still creeps toward the true level when the gain is 1/256.

Top module: `dc_blocker`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator clears. After that edge `dc_est` reads 0, `out_valid` reads 0 and `out_y` reads 0.
- R2: `dc_est` is the upper 8 bits of the 16-bit accumulator, read as a two's complement integer.
- R3: On a clock edge with `in_valid` high, the difference `in_x - dc_est` is formed in 8-bit two's complement. It wraps modulo 256 when it overflows.
- R4: On that edge, the difference is multiplied by `coef`, which is read as an unsigned fraction `coef/256`. The full 16-bit signed product is added to the accumulator, which wraps modulo 65536. `coef` = 0, or a zero difference, leaves the accumulator unchanged.
- R5: On a clock edge with `in_valid` low, the accumulator holds its value, so `dc_est` does not change, and `out_valid` is 0 after the edge.
- R6: One clock after an accepted sample, `out_valid` is 1. `out_y` then equals `in_x` minus the estimate from before that sample's update, clamped to the range -128 to +127.
- R7: A new `coef` value takes effect on the first accepted sample at or after the change, with no reset and no settling cycles.
- R8: The accumulator keeps the product's fractional bits. With `coef` = 1 and a constant input of 3 from reset, `dc_est` reaches 3 within 600 samples, even though each product is below one integer step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_x | input | 8 | Signed input sample |
| coef | input | 8 | Unsigned gain, value coef/256 |
| out_valid | output | 1 | Corrected sample is valid |
| out_y | output | 8 | Signed corrected sample, saturated |
| dc_est | output | 8 | Signed DC estimate |

## Verification
Five gains, from 255/256 down to 1/256, are each fed a scrambled sweep over all 256 input codes. The gains are chained without a reset, so the estimate enters each sweep from a non-zero state. This separates correct difference wrapping, correct product signing and correct clamping, because large gains drive the estimate to values where both the 8-bit wrap and the output clamp trigger. Idle cycles mixed into the sweeps show whether the accumulator or the valid flag moves without a strobe. A long constant input at the smallest gain fails only if the fractional accumulator bits are dropped or truncated.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  localparam int unsigned DCB_SAMPLE_W = 8;
  localparam int unsigned DCB_COEF_W   = 8;
endpackage

// File: rtl/dcb_diff.sv
module dcb_diff #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] est,
  output logic [W-1:0] diff
);
  // wrapping two's complement difference
  assign diff = x - est;
endmodule

// File: rtl/dcb_scale.sv
module dcb_scale #(
  parameter int unsigned W  = 8,
  parameter int unsigned KW = 8
) (
  input  logic [W-1:0]    diff,
  input  logic [KW-1:0]   coef,
  output logic [W+KW-1:0] prod
);
  localparam int unsigned PW = W + KW;
  logic signed [PW:0] full;
  // signed difference times unsigned fraction; magnitude fits in PW bits
  assign full = $signed(diff) * $signed({1'b0, coef});
  assign prod = full[PW-1:0];
endmodule

// File: rtl/dcb_accum.sv
module dcb_accum #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] prod,
  output logic [AW-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst)
      acc <= '0;
    else if (en)
      acc <= acc + prod;
  end
endmodule

// File: rtl/dcb_correct.sv
module dcb_correct #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] x,
  input  logic [W-1:0] est,
  output logic         out_valid,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MAX = {1'b1, {(W-1){1'b0}}};

  logic [W:0]   wide;
  logic [W-1:0] clamped;

  assign wide = {x[W-1], x} - {est[W-1], est};

  always_comb begin
    if (wide[W] != wide[W-1])
      clamped = wide[W] ? NEG_MAX : POS_MAX;
    else
      clamped = wide[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      y         <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid)
        y <= clamped;
    end
  end
endmodule

// File: rtl/dc_blocker.sv
module dc_blocker #(
  parameter int unsigned SAMPLE_W = dcb_pkg::DCB_SAMPLE_W,
  parameter int unsigned COEF_W   = dcb_pkg::DCB_COEF_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_x,
  input  logic [COEF_W-1:0]   coef,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_y,
  output logic [SAMPLE_W-1:0] dc_est
);
  localparam int unsigned ACC_W = SAMPLE_W + COEF_W;

  logic [SAMPLE_W-1:0] diff;
  logic [ACC_W-1:0]    prod;
  logic [ACC_W-1:0]    acc;

  assign dc_est = acc[ACC_W-1 -: SAMPLE_W];

  dcb_diff #(.W(SAMPLE_W)) u_diff (
    .x    (in_x),
    .est  (dc_est),
    .diff (diff)
  );

  dcb_scale #(.W(SAMPLE_W), .KW(COEF_W)) u_scale (
    .diff (diff),
    .coef (coef),
    .prod (prod)
  );

  dcb_accum #(.AW(ACC_W)) u_accum (
    .clk  (clk),
    .rst  (rst),
    .en   (in_valid),
    .prod (prod),
    .acc  (acc)
  );

  dcb_correct #(.W(SAMPLE_W)) u_correct (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .x         (in_x),
    .est       (dc_est),
    .out_valid (out_valid),
    .y         (out_y)
  );
endmodule

// File: rtl/dcb_checker.sv
module dcb_checker #(
  parameter int unsigned W  = 8,
  parameter int unsigned KW = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_x,
  input logic [KW-1:0] coef,
  input logic         out_valid,
  input logic [W-1:0] out_y,
  input logic [W-1:0] dc_est
);
  localparam logic signed [W:0] HI = (2**(W-1)) - 1;
  localparam logic signed [W:0] LO = -(2**(W-1));
  localparam logic [W-1:0] HI_Y = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] LO_Y = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0] gap;
  assign gap = $signed({in_x[W-1], in_x}) - $signed({dc_est[W-1], dc_est});

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (dc_est == '0 && !out_valid)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(dc_est) && !out_valid)); // R5

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R6

  AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && coef == '0) |=> $stable(dc_est)); // R4

  AST_ZERO_GAP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_x == dc_est) |=> ($stable(dc_est) && out_y == '0)); // R3

  AST_CLAMP_HI: assert property (@(posedge clk) disable iff (rst)
    (in_valid && gap > HI) |=> out_y == HI_Y); // R6

  AST_CLAMP_LO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && gap < LO) |=> out_y == LO_Y); // R6
endmodule

bind dc_blocker dcb_checker #(.W(SAMPLE_W), .KW(COEF_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_x      (in_x),
  .coef      (coef),
  .out_valid (out_valid),
  .out_y     (out_y),
  .dc_est    (dc_est)
);

// File: tb/sim_dc_blocker.sv
`timescale 1ns/1ps
module sim_dc_blocker;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_x = '0;
  logic [7:0] coef = '0;
  logic       out_valid;
  logic [7:0] out_y;
  logic [7:0] dc_est;

  int n_run = 0;
  int n_fail = 0;
  int m_acc = 0;

  always #10 clk = ~clk;

  dc_blocker u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .coef(coef),
    .out_valid(out_valid), .out_y(out_y), .dc_est(dc_est)
  );

  function automatic int s8(int v);
    int t = v & 255;
    return (t > 127) ? t - 256 : t;
  endfunction

  function automatic int clamp8(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic int m_est();
    return s8(m_acc >> 8);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // accepted sample; inputs are set at a negative edge, outputs checked at the next one
  task automatic push(input int x, input string tag);
    int e, ey;
    e  = m_est();
    ey = clamp8(x - e);
    in_x = x[7:0];
    in_valid = 1'b1;
    m_acc = (m_acc + s8(x - e) * int'(coef)) & 65535;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, {tag, " R6 valid"}, int'(out_valid), 1);
    chk(s8(int'(out_y)) == ey, {tag, " R6 out_y"}, s8(int'(out_y)), ey);
    chk(s8(int'(dc_est)) == m_est(), {tag, " R2/R3/R4 est"}, s8(int'(dc_est)), m_est());
  endtask

  task automatic idle(input int x);
    int e;
    e = m_est();
    in_x = x[7:0];
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 valid low", int'(out_valid), 0);
    chk(s8(int'(dc_est)) == e, "R5 est held", s8(int'(dc_est)), e);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b1;
    in_x = 8'd100;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    m_acc = 0;
    chk(dc_est == 8'd0, "R1 est", int'(dc_est), 0);
    chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
    chk(out_y == 8'd0, "R1 out_y", int'(out_y), 0);
  endtask

  initial begin
    int gains[5] = '{255, 128, 37, 8, 1};
    @(negedge clk);
    do_reset();
    // R7: gain changes between sweeps with no reset
    foreach (gains[g]) begin
      coef = gains[g][7:0];
      for (int i = 0; i < 256; i++) begin
        if (i % 16 == 5) idle(i);
        push(s8(i * 37 + g * 11), (i == 0) ? "R7 first after switch" : "sweep");
      end
    end
    // R4 zero gain keeps the estimate
    coef = 8'd0;
    for (int i = 0; i < 8; i++) push(s8(i * 53), "R4 zero gain");
    // R1 again, mid-run
    do_reset();
    // R8 fractional accumulation with the smallest gain
    coef = 8'd1;
    for (int i = 0; i < 600; i++) push(3, "R8 creep");
    chk(dc_est == 8'd3, "R8 settled est", s8(int'(dc_est)), 3);
    // fast gain on a large offset, then probe the clamp
    coef = 8'd200;
    for (int i = 0; i < 20; i++) push(-110, "R6 settle neg");
    push(127, "R6 clamp high");
    push(-128, "R3 wrap");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_run++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule